// File: doc/BRIEF.md
# Serial LED Shift-Latch with Fault Capture

This block is the digital core of a sixteen-channel LED sink driver. A serial bit stream enters on `ser_in` and is shifted on each serial clock pulse. The top stage of the register appears on `ser_out`, so several devices can be chained in a cascade. A level-sensitive latch copies the register while `lat_en` is high and freezes it while `lat_en` is low. The latched bits set the sixteen channel-enable outputs, and `out_off` can blank all of them at once.

When `det_mode` is high, the block is in a fault-detection mode. The capture window opens when `out_off` falls. While the window is open the channels are driven from the latch, the serial input is ignored, and the serial clock pulses are counted. On the third pulse, external per-channel comparator flags are loaded into the shift register. A flag is 0 for a faulty channel and 1 for a good one. This load only happens if at least `MIN_GAP` system-clock cycles have passed since `out_off` fell. If the third pulse comes earlier, the block raises `early_err` and leaves the register as it was. Once `out_off` is high again, the captured code shifts out on `ser_out`, highest channel first.

The serial clock is not used as a clock. `sck_en` is a one-cycle enable sampled by the faster system clock `clk`. Mode-entry decoding lives elsewhere and arrives here as the `det_mode` level.

Top module: `led_shift_latch`

## Requirements
- R1: A synchronous reset clears the shift register and the latch to all zeros, so `ser_out` is 0 and `drive` is 0 after reset.
- R2: Outside a capture window, each cycle with `sck_en` high shifts `ser_in` into bit 0 and moves every bit up one place. `ser_out` always shows bit 15, so the first bit shifted in leaves first.
- R3: While `lat_en` is high the latch is transparent to the shift register. While it is low the latch holds, and `drive` does not change even when the register shifts.
- R4: While `out_off` is high, all bits of `drive` are 0. While it is low, `drive[i]` equals latched bit i, where 1 means the channel is on. This also holds inside a capture window.
- R5: A capture window is open while `det_mode` is high and `out_off` is low. Inside it, `ser_in` is ignored and serial pulses do not shift the register.
- R6: The third `sck_en` pulse in a window loads `det_flags` into the shift register, provided at least `MIN_GAP` cycles have passed since the cycle in which `out_off` fell. Flag value 0 means fault and 1 means normal.
- R7: If that third pulse comes fewer than `MIN_GAP` cycles after the fall, `early_err` is high for exactly the next cycle and the register keeps its value.
- R8: After `out_off` returns high, the captured code leaves on `ser_out`: bit 15 before the first pulse, then bits 14, 13 and onward, one per pulse.
- R9: Pulses after the third in the same window change nothing. A new fall of `out_off` restarts both the pulse count and the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_en | input | 1 | One-cycle serial clock pulse |
| ser_in | input | 1 | Serial data in |
| lat_en | input | 1 | Latch transparent when high, holds when low |
| out_off | input | 1 | Forces all channels off when high |
| det_mode | input | 1 | Fault-detection mode selected |
| det_flags | input | CH | Comparator flags per channel, 0 = fault |
| ser_out | output | 1 | Shift register bit 15, cascade output |
| drive | output | CH | Channel enables, 1 = on |
| early_err | output | 1 | Third pulse came before the minimum delay |

## Verification
The hard case is the timing of the third pulse against the delay since `out_off` fell, one cycle each side of `MIN_GAP`, while extra pulses and a changing `ser_in` try to corrupt the register. Directed sequences place the third pulse well past the delay, then well inside it, then in a reopened window. The captured code is then read back over the serial output. Random stimulus toggles every input, including mode and blanking, so that windows open and close at arbitrary pulse counts. Every cycle is compared against a bench model.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  typedef logic [1:0] edge_cnt_t;
  localparam edge_cnt_t CAP_EDGE = 2'd2;  // count value seen on the third pulse

  function automatic edge_cnt_t cnt_after(input edge_cnt_t cur, input logic pulse);
    return (pulse && cur != 2'd3) ? cur + 2'd1 : cur;
  endfunction
endpackage

// File: rtl/lsl_capture_ctl.sv
module lsl_capture_ctl
  import lsl_pkg::*;
#(
  parameter int unsigned MIN_GAP = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_en,
  input  logic det_mode,
  input  logic out_off,
  output logic win,
  output logic cap_ok,
  output logic cap_early,
  output logic early_err
);
  localparam int unsigned EW = $clog2(MIN_GAP + 1);

  logic          off_q;
  logic [EW-1:0] el_q, el_cur;
  edge_cnt_t     cnt_q, cnt_cur;
  logic          off_fall, third;

  function automatic logic gap_met(input logic [EW-1:0] e);
    return 32'(e) >= MIN_GAP;
  endfunction

  assign off_fall  = off_q & ~out_off;
  assign win       = det_mode & ~out_off;
  assign cnt_cur   = off_fall ? '0 : cnt_q;
  assign el_cur    = off_fall ? '0 : el_q;
  assign third     = sck_en & win & (cnt_cur == CAP_EDGE);
  assign cap_ok    = third & gap_met(el_cur);
  assign cap_early = third & ~gap_met(el_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= 1'b1;
      el_q      <= '0;
      cnt_q     <= '0;
      early_err <= 1'b0;
    end else begin
      off_q     <= out_off;
      cnt_q     <= cnt_after(cnt_cur, sck_en & win);
      early_err <= cap_early;
      if (off_fall)
        el_q <= EW'(1);
      else if (!gap_met(el_q))
        el_q <= el_q + EW'(1);
    end
  end

  p_early_flag_r7: assert property (@(posedge clk) disable iff (rst)
    cap_early |=> early_err);
  p_early_only_r7: assert property (@(posedge clk) disable iff (rst)
    !cap_early |=> !early_err);
endmodule

// File: rtl/lsl_shifter.sv
module lsl_shifter #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_en,
  input  logic          ser_in,
  input  logic          hold,
  input  logic          load,
  input  logic [CH-1:0] load_val,
  output logic [CH-1:0] sr
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (load)
        sr <= load_val;
      else if (sck_en && !hold)
        sr <= {sr[CH-2:0], ser_in};
    end
  end

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sr == '0);
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    seen && sck_en && !hold && !load |=>
      sr[0] == $past(ser_in) && sr[CH-1:1] == $past(sr[CH-2:0]));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    seen && load |=> sr == $past(load_val));
  p_ignore_r5: assert property (@(posedge clk) disable iff (rst)
    seen && hold && !load |=> $stable(sr));
endmodule

// File: rtl/lsl_latch_gate.sv
module lsl_latch_gate #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_en,
  input  logic          out_off,
  input  logic [CH-1:0] sr,
  output logic [CH-1:0] drive
);
  logic [CH-1:0] held_q, view;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= '0;
      seen   <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (lat_en) held_q <= sr;
    end
  end

  assign view = lat_en ? sr : held_q;

  for (genvar i = 0; i < CH; i++) begin : g_chan
    assign drive[i] = view[i] & ~out_off;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    seen && !lat_en && $past(lat_en) == 1'b0 && !out_off && $past(out_off) == 1'b0
      |-> $stable(drive));
endmodule

// File: rtl/led_shift_latch.sv
module led_shift_latch #(
  parameter int unsigned CH      = 16,
  parameter int unsigned MIN_GAP = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck_en,
  input  logic          ser_in,
  input  logic          lat_en,
  input  logic          out_off,
  input  logic          det_mode,
  input  logic [CH-1:0] det_flags,
  output logic          ser_out,
  output logic [CH-1:0] drive,
  output logic          early_err
);
  logic          win, cap_ok, cap_early;
  logic [CH-1:0] sr;

  lsl_capture_ctl #(.MIN_GAP(MIN_GAP)) u_ctl (
    .clk(clk), .rst(rst), .sck_en(sck_en), .det_mode(det_mode), .out_off(out_off),
    .win(win), .cap_ok(cap_ok), .cap_early(cap_early), .early_err(early_err)
  );

  lsl_shifter #(.CH(CH)) u_sr (
    .clk(clk), .rst(rst), .sck_en(sck_en), .ser_in(ser_in), .hold(win),
    .load(cap_ok), .load_val(det_flags), .sr(sr)
  );

  lsl_latch_gate #(.CH(CH)) u_lat (
    .clk(clk), .rst(rst), .lat_en(lat_en), .out_off(out_off), .sr(sr), .drive(drive)
  );

  assign ser_out = sr[CH-1];
endmodule

// File: tb/sim_led_shift_latch.sv
module sim_led_shift_latch;
  localparam int GAP = 12;
  logic clk = 0, rst = 1;
  logic b_sck = 0, b_sin = 0, b_lat = 0, b_off = 1, b_det = 0;
  logic [15:0] b_flags = '0;
  logic ser_out, early_err;
  logic [15:0] drive;
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] m_sr, m_lat;
  logic m_offp, m_err;
  int m_fall, m_cnt;

  always #10 clk = ~clk;

  led_shift_latch #(.CH(16), .MIN_GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .sck_en(b_sck), .ser_in(b_sin), .lat_en(b_lat),
    .out_off(b_off), .det_mode(b_det), .det_flags(b_flags),
    .ser_out(ser_out), .drive(drive), .early_err(early_err));

  function automatic logic [15:0] exp_drive();
    return b_off ? 16'h0 : (b_lat ? m_sr : m_lat);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 drive", drive, exp_drive());
    chk("R2 ser_out", 16'(ser_out), 16'(m_sr[15]));
    chk("R7 early_err", 16'(early_err), 16'(m_err));
  endtask

  task automatic step();
    logic win, fall, third;
    int cc, gap;
    logic [15:0] nsr;
    win  = b_det && !b_off;
    fall = m_offp && !b_off;
    cc   = fall ? 0 : m_cnt;
    gap  = fall ? 0 : cyc - m_fall;
    third = b_sck && win && cc == 2;
    nsr = m_sr;
    if (third) begin
      if (gap >= GAP) nsr = b_flags;
    end else if (b_sck && !win) nsr = {m_sr[14:0], b_sin};
    if (b_lat) m_lat = m_sr;
    m_err = third && gap < GAP;
    if (fall) m_fall = cyc;
    m_cnt = (win && b_sck && cc < 3) ? cc + 1 : cc;
    m_offp = b_off;
    m_sr = nsr;
    @(posedge clk); #5; cyc++;
  endtask

  task automatic tick();
    #1 check_all();
    step();
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #5 rst = 0;
    cyc = 0; m_sr = '0; m_lat = '0; m_offp = 1; m_err = 0; m_fall = 0; m_cnt = 0;
  endtask

  task automatic shift16(logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      b_sck = 1; b_sin = v[i]; tick();
    end
    b_sck = 0;
  endtask

  task automatic read16(output logic [15:0] v);
    b_off = 1; b_sin = 0;
    for (int i = 15; i >= 0; i--) begin
      b_sck = 1; #1 v[i] = ser_out; tick();
    end
    b_sck = 0;
  endtask

  task automatic idle(int n);
    b_sck = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd, saved;
    void'($urandom(32'd4242));
    do_reset();
    b_lat = 1; b_off = 0; #1;
    chk("R1 drive after reset", drive, 16'h0);
    chk("R1 ser_out after reset", 16'(ser_out), 16'h0);
    b_lat = 0; b_off = 1;

    // R2, R3 shift then latch
    shift16(16'hA5C3);
    b_lat = 1; tick(); b_lat = 0; b_off = 0; #1;
    chk("R3 latched value", drive, 16'hA5C3);
    shift16(16'h0F0F); #1;
    chk("R3 hold while shifting", drive, 16'hA5C3);
    b_off = 1; #1;
    chk("R4 blanked", drive, 16'h0);

    // R6 capture with enough delay, R9 extra pulses, R8 readout
    b_det = 1; idle(1);
    b_off = 0; idle(1);
    b_sck = 1; b_sin = 1; tick(); tick();
    idle(GAP);
    b_flags = 16'h7EB1; b_sck = 1; tick();
    b_flags = 16'hFFFF; b_sin = 0; tick(); tick();
    b_sck = 0; #1;
    chk("R4 drive in window", drive, 16'hA5C3);
    read16(rd);
    chk("R6 R8 captured code", rd, 16'h7EB1);

    // R7 early third pulse, R5 ser_in ignored
    shift16(16'h3C96);
    b_off = 0; idle(1);
    b_sin = 1; b_flags = 16'h0000; b_sck = 1; tick(); tick(); tick();
    b_sck = 0; #1;
    chk("R7 early_err pulse", 16'(early_err), 16'h1);
    tick(); #1;
    chk("R7 early_err one cycle", 16'(early_err), 16'h0);
    read16(rd);
    chk("R5 R7 register kept", rd, 16'h3C96);

    // R9 new window restarts count and delay
    b_off = 0; idle(GAP + 2);
    b_off = 1; idle(1);
    b_off = 0; b_sck = 1; tick(); tick(); idle(GAP - 3);
    b_flags = 16'h1234; b_sck = 1; tick(); b_sck = 0; #1;
    chk("R9 restart early flag", 16'(early_err), 16'h1);
    idle(1);
    b_off = 1; idle(1); b_off = 0; idle(GAP);
    b_sck = 1; tick(); tick(); tick(); b_sck = 0;
    read16(rd);
    chk("R9 restart capture", rd, 16'h1234);

    // random mix
    b_det = 0;
    for (int i = 0; i < 4000; i++) begin
      b_sck = $urandom_range(0, 1);
      b_sin = $urandom_range(0, 1);
      b_lat = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) b_off = ~b_off;
      if ($urandom_range(0, 63) == 0) b_det = ~b_det;
      b_flags = 16'($urandom);
      if ($urandom_range(0, 3) == 0) b_sck = 0;
      tick();
    end
    saved = m_sr;
    read16(rd);
    chk("R8 final readout", rd, saved);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule